// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block runs one transfer on an auxiliary channel engine from start to finish. The engine reports a busy flag, three sticky completion flags (done, timeout error, receive error) and a received-size field. On a start request the controller does the following in order:

- It aborts at once if the port is external and has no device attached.
- It waits a bounded time for the channel to become idle.
- It rejects transfer lengths the engine cannot hold.
- It walks through a sequence of clock-divider settings, making a fixed number of launch attempts with each one.

After every attempt it waits for completion and then clears the sticky flags with a one-cycle clear pulse. It then picks a retry policy from the flags. A timeout error relaunches at once. A receive error first waits a back-off interval.

The transfer ends in one of two ways: a clean completion, or the divider source returning zero. The controller then reports a result code and a received byte count. The count is clamped to the caller's capacity. The result is held until the next start. All timers count a 1 µs tick input, so the surrounding clock frequency does not matter.

Top module: `aux_retry_ctrl`

## Requirements
- R1: After reset `res_valid`, `ch_launch` and `ch_clear` are 0.
- R2: A start with `is_embedded`=0 and `port_connected`=0 gives `res_valid`=1 and `res_code`=4 (no device) in the next cycle, with no launch. When `is_embedded`=1 the connection input is ignored.
- R3: `ch_busy` is sampled up to IDLE_POLLS (3) times, POLL_GAP_US ticks apart. If every sample is busy the result is code 1 (busy) with no launch. If any sample is idle the transfer proceeds.
- R4: After the idle check, `tx_len` or `rx_cap` above MAX_BYTES (20) gives code 5 (too big) with no launch.
- R5: Each attempt is a one-cycle `ch_launch` that carries the current divider on `ch_div`. The following wait ends when `ch_busy` is low or after DONE_WAIT_US ticks, and it is followed by exactly one `ch_clear` cycle.
- R6: A timeout error seen at clear time relaunches in the very next cycle, without back-off.
- R7: A receive error without a timeout error waits RX_BACKOFF_US ticks before the next launch.
- R8: Up to ATTEMPTS (5) launches are made per divider. `div_idx` then advances by one. A zero `div_val` ends the sequence, and a zero divider is never launched.
- R9: The final verdict comes from the last status seen. Not done gives code 1. Done with a receive error gives code 2 (I/O). Done with only a timeout error gives code 3. A receive error takes precedence over a timeout error.
- R10: After a clean done, a received size of 0 or above MAX_BYTES gives code 1. Otherwise the result is code 0 with `res_count` = min(size, `rx_cap`).
- R11: `res_valid`, `res_code` and `res_count` stay stable until the next start. A start that arrives while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| tx_len | input | 5 | Bytes to send |
| rx_cap | input | 5 | Receive capacity of the caller |
| is_embedded | input | 1 | Port is an embedded panel (connection not checked) |
| port_connected | input | 1 | A sink is attached |
| div_idx | output | IDX_W | Index into the divider source |
| div_val | input | DIV_W | Divider for `div_idx`; zero ends the sequence |
| ch_busy | input | 1 | Channel engine busy |
| ch_done | input | 1 | Sticky done flag |
| ch_tmo_err | input | 1 | Sticky timeout-error flag |
| ch_rx_err | input | 1 | Sticky receive-error flag |
| ch_rx_size | input | 5 | Received byte count from the engine |
| ch_launch | output | 1 | One-cycle launch request |
| ch_div | output | DIV_W | Divider used for the launch |
| ch_clear | output | 1 | One-cycle write-one-to-clear of the three sticky flags |
| res_valid | output | 1 | Result available |
| res_code | output | 3 | 0 ok, 1 busy, 2 I/O, 3 timeout, 4 no device, 5 too big |
| res_count | output | 5 | Received bytes returned (0 unless ok) |

## Verification
The bench drives a scripted channel model whose reply can change between the first and the later attempts. This covers the following cases and the bug each one catches:

- **Back-off gap.** The number of cycles between a clear and the next launch tells timeout retries apart from receive-error retries. A design that swapped the two policies, or backed off on both, shows the wrong gap.
- **Divider walk.** An engine that fails every attempt must see exactly ten launches across two nonzero dividers, and the last launch must carry the second divider. Miscounted attempts, or an off-by-one in the divider walk, change that count.
- **Final verdict.** All receive errors, combined receive-and-timeout errors, no response at all, and a divider source that is zero from the start must yield I/O, I/O, busy and busy respectively. A wrong flag priority shows up as a timeout code.
- **Size handling and input ordering.** Forbidden sizes, clamping to the caller's capacity, a busy channel that never frees, and oversized lengths must each return their own code with no launch where required. A start pulse issued mid-transfer must not add launches.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

    localparam int AUX_SZ_W = 5;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_BUSY    = 3'd1,
        RES_IO      = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_NODEV   = 3'd4,
        RES_TOOBIG  = 3'd5
    } aux_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_PGAP,
        ST_DIVCHK,
        ST_LAUNCH,
        ST_WAIT,
        ST_CLEAR,
        ST_BACKOFF
    } aux_state_e;

    typedef struct packed {
        logic                done;
        logic                tmo;
        logic                rxe;
        logic [AUX_SZ_W-1:0] size;
    } aux_stat_t;

endpackage

// File: rtl/aux_tick_timer.sv
module aux_tick_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expire = run && tick && (cnt_q == limit - CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run || expire) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5/R7: a running interval never passes its limit
    a_r5_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/aux_result_eval.sv
module aux_result_eval
    import aux_retry_pkg::*;
#(
    parameter int MAX_BYTES = 20
) (
    input  aux_stat_t           stat,
    input  logic [AUX_SZ_W-1:0] cap,
    output aux_res_e            code,
    output logic [AUX_SZ_W-1:0] count
);

    localparam logic [AUX_SZ_W-1:0] MAXB = AUX_SZ_W'(MAX_BYTES);

    always_comb begin
        count = '0;
        if (!stat.done) begin
            code = RES_BUSY;
        end else if (stat.rxe) begin
            code = RES_IO;
        end else if (stat.tmo) begin
            code = RES_TIMEOUT;
        end else if (stat.size == '0 || stat.size > MAXB) begin
            code = RES_BUSY;
        end else begin
            code  = RES_OK;
            count = (stat.size > cap) ? cap : stat.size;
        end
    end

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
    import aux_retry_pkg::*;
#(
    parameter int MAX_BYTES     = 20,
    parameter int IDLE_POLLS    = 3,
    parameter int POLL_GAP_US   = 1000,
    parameter int DONE_WAIT_US  = 10000,
    parameter int RX_BACKOFF_US = 400,
    parameter int ATTEMPTS      = 5,
    parameter int DIV_W         = 8,
    parameter int IDX_W         = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_us,
    input  logic                start,
    input  logic [AUX_SZ_W-1:0] tx_len,
    input  logic [AUX_SZ_W-1:0] rx_cap,
    input  logic                is_embedded,
    input  logic                port_connected,
    output logic [IDX_W-1:0]    div_idx,
    input  logic [DIV_W-1:0]    div_val,
    input  logic                ch_busy,
    input  logic                ch_done,
    input  logic                ch_tmo_err,
    input  logic                ch_rx_err,
    input  logic [AUX_SZ_W-1:0] ch_rx_size,
    output logic                ch_launch,
    output logic [DIV_W-1:0]    ch_div,
    output logic                ch_clear,
    output logic                res_valid,
    output logic [2:0]          res_code,
    output logic [AUX_SZ_W-1:0] res_count
);

    localparam int TMAX_A = (POLL_GAP_US > DONE_WAIT_US) ? POLL_GAP_US : DONE_WAIT_US;
    localparam int TMAX   = (TMAX_A > RX_BACKOFF_US) ? TMAX_A : RX_BACKOFF_US;
    localparam int CNT_W  = $clog2(TMAX + 1);
    localparam int PC_W   = $clog2(IDLE_POLLS + 1);
    localparam int AC_W   = $clog2(ATTEMPTS + 1);

    localparam logic [CNT_W-1:0]    LIM_GAP  = CNT_W'(POLL_GAP_US);
    localparam logic [CNT_W-1:0]    LIM_WAIT = CNT_W'(DONE_WAIT_US);
    localparam logic [CNT_W-1:0]    LIM_BACK = CNT_W'(RX_BACKOFF_US);
    localparam logic [PC_W-1:0]     POLL_LAST = PC_W'(IDLE_POLLS - 1);
    localparam logic [AC_W-1:0]     ATT_LAST  = AC_W'(ATTEMPTS - 1);
    localparam logic [AUX_SZ_W-1:0] MAXB      = AUX_SZ_W'(MAX_BYTES);

    typedef struct packed {
        aux_state_e          state;
        logic [PC_W-1:0]     poll_cnt;
        logic [AC_W-1:0]     att_cnt;
        logic [IDX_W-1:0]    idx;
        logic [DIV_W-1:0]    div;
        logic [AUX_SZ_W-1:0] len;
        logic [AUX_SZ_W-1:0] cap;
        aux_stat_t           stat;
        logic                res_valid;
        aux_res_e            res_code;
        logic [AUX_SZ_W-1:0] res_count;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic                tmr_run;
    logic [CNT_W-1:0]    tmr_lim;
    logic                tmr_exp;
    logic                retry;
    aux_stat_t           live_stat;
    aux_stat_t           eval_stat;
    aux_res_e            ev_code;
    logic [AUX_SZ_W-1:0] ev_count;

    assign live_stat = '{done: ch_done, tmo: ch_tmo_err, rxe: ch_rx_err, size: ch_rx_size};
    assign eval_stat = (r_q.state == ST_CLEAR) ? live_stat : r_q.stat;

    aux_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .tick   (tick_us),
        .limit  (tmr_lim),
        .expire (tmr_exp)
    );

    aux_result_eval #(.MAX_BYTES(MAX_BYTES)) u_eval (
        .stat  (eval_stat),
        .cap   (r_q.cap),
        .code  (ev_code),
        .count (ev_count)
    );

    always_comb begin
        r_d     = r_q;
        retry   = 1'b0;
        tmr_run = 1'b0;
        tmr_lim = LIM_WAIT;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.res_valid = 1'b0;
                    r_d.poll_cnt  = '0;
                    r_d.att_cnt   = '0;
                    r_d.idx       = '0;
                    r_d.stat      = '0;
                    r_d.len       = tx_len;
                    r_d.cap       = rx_cap;
                    if (!is_embedded && !port_connected) begin
                        r_d.res_valid = 1'b1;
                        r_d.res_code  = RES_NODEV;
                        r_d.res_count = '0;
                    end else begin
                        r_d.state = ST_POLL;
                    end
                end
            end
            ST_POLL: begin
                if (!ch_busy) begin
                    if (r_q.len > MAXB || r_q.cap > MAXB) begin
                        r_d.state     = ST_IDLE;
                        r_d.res_valid = 1'b1;
                        r_d.res_code  = RES_TOOBIG;
                        r_d.res_count = '0;
                    end else begin
                        r_d.state = ST_DIVCHK;
                    end
                end else if (r_q.poll_cnt == POLL_LAST) begin
                    r_d.state     = ST_IDLE;
                    r_d.res_valid = 1'b1;
                    r_d.res_code  = RES_BUSY;
                    r_d.res_count = '0;
                end else begin
                    r_d.poll_cnt = r_q.poll_cnt + PC_W'(1);
                    r_d.state    = ST_PGAP;
                end
            end
            ST_PGAP: begin
                tmr_run = 1'b1;
                tmr_lim = LIM_GAP;
                if (tmr_exp) begin
                    r_d.state = ST_POLL;
                end
            end
            ST_DIVCHK: begin
                if (div_val == '0) begin
                    r_d.state     = ST_IDLE;
                    r_d.res_valid = 1'b1;
                    r_d.res_code  = ev_code;
                    r_d.res_count = ev_count;
                end else begin
                    r_d.div     = div_val;
                    r_d.att_cnt = '0;
                    r_d.state   = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                tmr_run = 1'b1;
                tmr_lim = LIM_WAIT;
                if (!ch_busy || tmr_exp) begin
                    r_d.state = ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                r_d.stat = live_stat;
                if (ch_tmo_err) begin
                    retry = 1'b1;
                end else if (ch_rx_err) begin
                    r_d.state = ST_BACKOFF;
                end else if (ch_done) begin
                    r_d.state     = ST_IDLE;
                    r_d.res_valid = 1'b1;
                    r_d.res_code  = ev_code;
                    r_d.res_count = ev_count;
                end else begin
                    retry = 1'b1;
                end
            end
            ST_BACKOFF: begin
                tmr_run = 1'b1;
                tmr_lim = LIM_BACK;
                if (tmr_exp) begin
                    retry = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (retry) begin
            if (r_q.att_cnt == ATT_LAST) begin
                r_d.idx   = r_q.idx + IDX_W'(1);
                r_d.state = ST_DIVCHK;
            end else begin
                r_d.att_cnt = r_q.att_cnt + AC_W'(1);
                r_d.state   = ST_LAUNCH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_idx   = r_q.idx;
    assign ch_div    = r_q.div;
    assign ch_launch = (r_q.state == ST_LAUNCH);
    assign ch_clear  = (r_q.state == ST_CLEAR);
    assign res_valid = r_q.res_valid;
    assign res_code  = r_q.res_code;
    assign res_count = r_q.res_count;

    // R2: a disconnected external port reports no-device next cycle
    a_r2_nodev: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start && !is_embedded && !port_connected)
        |=> (res_valid && res_code == 3'd4 && !ch_launch));

    // R5: every clear pulse closes a completion wait
    a_r5_clear_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ch_clear |-> ($past(r_q.state) == ST_WAIT));

    // R6: a timeout error relaunches without back-off
    a_r6_tmo_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_clear && ch_tmo_err && r_q.att_cnt != ATT_LAST) |=> ch_launch);

    // R7: a receive error never relaunches immediately
    a_r7_rx_backoff: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_clear && ch_rx_err && !ch_tmo_err) |=> !ch_launch);

    // R8: a zero divider is never launched
    a_r8_nonzero_div: assert property (@(posedge clk) disable iff (!rst_n)
        ch_launch |-> (ch_div != '0));

    // R10: a good result never exceeds the caller capacity
    a_r10_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 3'd0) |-> (res_count <= r_q.cap && res_count != '0 || r_q.cap == '0));

    // R11: the result holds until the next start
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !start) |=> (res_valid && $stable(res_code) && $stable(res_count)));

endmodule

// File: tb/aux_retry_ctrl_tb.sv
module aux_retry_ctrl_tb;

    localparam int PGAP = 6;
    localparam int DWAIT = 30;
    localparam int RXB = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       start = 1'b0;
    logic [4:0] tx_len = '0;
    logic [4:0] rx_cap = '0;
    logic       is_embedded = 1'b0;
    logic       port_connected = 1'b1;
    logic [2:0] div_idx;
    logic [7:0] div_val;
    logic       ch_busy;
    logic       ch_launch;
    logic [7:0] ch_div;
    logic       ch_clear;
    logic       res_valid;
    logic [2:0] res_code;
    logic [4:0] res_count;

    // channel model state
    logic       m_busy = 1'b0;
    logic       m_done = 1'b0;
    logic       m_tmo = 1'b0;
    logic       m_rx = 1'b0;
    logic [4:0] m_size = '0;
    int         m_lat = 0;
    int         cur_kind = 0;
    int         launches = 0;
    int         clears = 0;
    int         last_div = 0;
    int         gap_last = 0;
    int         clr_cyc = 0;
    int         cyc = 0;
    int         base_l = 0;
    // kinds: 0 clean done, 1 done+timeout, 2 done+rx error, 3 no response, 4 done+timeout+rx error
    int         kfirst = 0;
    int         krest = 0;
    int         resp_size = 4;
    int         div_mode = 0;
    logic       busy_force = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(negedge clk) tick_us <= ~tick_us;

    assign ch_busy = m_busy | busy_force;
    assign div_val = (div_mode != 0) ? 8'd0 :
                     (div_idx == 3'd0) ? 8'd7 : (div_idx == 3'd1) ? 8'd9 : 8'd0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ch_launch) begin
            m_busy   <= 1'b1;
            m_lat    <= 3;
            launches <= launches + 1;
            last_div <= int'(ch_div);
            gap_last <= cyc - clr_cyc;
            cur_kind <= (launches == base_l) ? kfirst : krest;
        end else if (m_busy && cur_kind != 3) begin
            if (m_lat > 0) begin
                m_lat <= m_lat - 1;
            end else begin
                m_busy <= 1'b0;
                m_done <= 1'b1;
                m_tmo  <= (cur_kind == 1 || cur_kind == 4);
                m_rx   <= (cur_kind == 2 || cur_kind == 4);
                m_size <= 5'(resp_size);
            end
        end
        if (ch_clear) begin
            m_done  <= 1'b0;
            m_tmo   <= 1'b0;
            m_rx    <= 1'b0;
            clr_cyc <= cyc;
            clears  <= clears + 1;
            if (cur_kind == 3) m_busy <= 1'b0;
        end
    end

    aux_retry_ctrl #(
        .POLL_GAP_US   (PGAP),
        .DONE_WAIT_US  (DWAIT),
        .RX_BACKOFF_US (RXB)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_us        (tick_us),
        .start          (start),
        .tx_len         (tx_len),
        .rx_cap         (rx_cap),
        .is_embedded    (is_embedded),
        .port_connected (port_connected),
        .div_idx        (div_idx),
        .div_val        (div_val),
        .ch_busy        (ch_busy),
        .ch_done        (m_done),
        .ch_tmo_err     (m_tmo),
        .ch_rx_err      (m_rx),
        .ch_rx_size     (m_size),
        .ch_launch      (ch_launch),
        .ch_div         (ch_div),
        .ch_clear       (ch_clear),
        .res_valid      (res_valid),
        .res_code       (res_code),
        .res_count      (res_count)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input string what, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic run_txn(input int tx, input int cap, output int code, output int cnt, output int dur);
        base_l = launches;
        @(negedge clk);
        tx_len = 5'(tx);
        rx_cap = 5'(cap);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dur = 1;
        while (!res_valid && dur < 6000) begin
            @(negedge clk);
            dur++;
        end
        code = int'(res_code);
        cnt  = int'(res_count);
    endtask

    task automatic t_reset();
        check("R1", "res_valid after reset", int'(res_valid), 0);
        check("R1", "ch_launch after reset", int'(ch_launch), 0);
        check("R1", "ch_clear after reset", int'(ch_clear), 0);
    endtask

    task automatic t_clean();
        int code, cnt, dur;
        kfirst = 0; krest = 0; resp_size = 5;
        run_txn(4, 17, code, cnt, dur);
        check("R10", "clean code", code, 0);
        check("R10", "clean count", cnt, 5);
        check("R5", "one launch", launches - base_l, 1);
        check("R5", "launch divider", last_div, 7);
        check("R5", "single clear", clears - base_l, 1);
    endtask

    task automatic t_clamp_and_size();
        int code, cnt, dur;
        kfirst = 0; krest = 0; resp_size = 12;
        run_txn(4, 4, code, cnt, dur);
        check("R10", "clamped code", code, 0);
        check("R10", "clamped count", cnt, 4);
        resp_size = 0;
        run_txn(4, 10, code, cnt, dur);
        check("R10", "size zero code", code, 1);
        resp_size = 21;
        run_txn(4, 10, code, cnt, dur);
        check("R10", "size 21 code", code, 1);
        resp_size = 20;
        run_txn(4, 20, code, cnt, dur);
        check("R10", "size 20 count", cnt, 20);
    endtask

    task automatic t_nodev();
        int code, cnt, dur;
        kfirst = 0; krest = 0; resp_size = 3;
        is_embedded = 1'b0; port_connected = 1'b0;
        run_txn(4, 10, code, cnt, dur);
        check("R2", "disconnected code", code, 4);
        check("R2", "disconnected launches", launches - base_l, 0);
        is_embedded = 1'b1;
        run_txn(4, 10, code, cnt, dur);
        check("R2", "embedded ignores connection", code, 0);
        is_embedded = 1'b0; port_connected = 1'b1;
    endtask

    task automatic t_busy_poll();
        int code, cnt, dur;
        kfirst = 0; krest = 0; resp_size = 2;
        busy_force = 1'b1;
        run_txn(4, 10, code, cnt, dur);
        check("R3", "stuck busy code", code, 1);
        check("R3", "stuck busy launches", launches - base_l, 0);
        check_rng("R3", "stuck busy duration", dur, 4 * PGAP - 2, 4 * PGAP + 8);
        base_l = launches;
        fork
            begin
                repeat (8) @(negedge clk);
                busy_force = 1'b0;
            end
            run_txn(4, 10, code, cnt, dur);
        join
        check("R3", "busy frees before last poll", code, 0);
        check("R3", "launch after idle", launches - base_l, 1);
        busy_force = 1'b1;
        run_txn(25, 10, code, cnt, dur);
        check("R4", "busy beats too-big", code, 1);
        busy_force = 1'b0;
    endtask

    task automatic t_too_big();
        int code, cnt, dur;
        run_txn(21, 10, code, cnt, dur);
        check("R4", "tx 21 code", code, 5);
        check("R4", "tx 21 launches", launches - base_l, 0);
        run_txn(4, 21, code, cnt, dur);
        check("R4", "rx 21 code", code, 5);
        run_txn(20, 20, code, cnt, dur);
        check("R4", "20 bytes accepted", code, 0);
    endtask

    task automatic t_tmo_retry();
        int code, cnt, dur;
        kfirst = 1; krest = 0; resp_size = 6;
        run_txn(4, 10, code, cnt, dur);
        check("R6", "retry code", code, 0);
        check("R6", "two launches", launches - base_l, 2);
        check("R6", "immediate relaunch gap", gap_last, 1);
    endtask

    task automatic t_rx_backoff();
        int code, cnt, dur;
        kfirst = 2; krest = 0; resp_size = 6;
        run_txn(4, 10, code, cnt, dur);
        check("R7", "retry code", code, 0);
        check("R7", "two launches", launches - base_l, 2);
        check_rng("R7", "back-off gap", gap_last, 2 * RXB, 2 * RXB + 3);
    endtask

    task automatic t_div_seq();
        int code, cnt, dur;
        kfirst = 1; krest = 1;
        run_txn(4, 10, code, cnt, dur);
        check("R8", "launches over two dividers", launches - base_l, 10);
        check("R8", "last divider", last_div, 9);
        check("R9", "all timeouts code", code, 3);
        kfirst = 2; krest = 2;
        run_txn(4, 10, code, cnt, dur);
        check("R9", "all rx errors code", code, 2);
        kfirst = 4; krest = 4;
        run_txn(4, 10, code, cnt, dur);
        check("R9", "rx error over timeout", code, 2);
        kfirst = 3; krest = 3;
        run_txn(4, 10, code, cnt, dur);
        check("R9", "never done code", code, 1);
        check("R5", "no response launches", launches - base_l, 10);
        div_mode = 1; kfirst = 0; krest = 0;
        run_txn(4, 10, code, cnt, dur);
        check("R8", "zero divider code", code, 1);
        check("R8", "zero divider launches", launches - base_l, 0);
        div_mode = 0;
    endtask

    task automatic t_hold();
        int code, cnt, dur, c0, n0;
        kfirst = 0; krest = 0; resp_size = 7;
        run_txn(4, 10, code, cnt, dur);
        repeat (12) @(negedge clk);
        check("R11", "valid held", int'(res_valid), 1);
        check("R11", "code held", int'(res_code), 0);
        check("R11", "count held", int'(res_count), 7);
        kfirst = 3; krest = 3;
        base_l = launches;
        n0 = launches;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        c0 = 0;
        while (!res_valid && c0 < 6000) begin
            @(negedge clk);
            c0++;
        end
        check("R11", "start mid-run ignored", launches - n0, 10);
        check("R11", "mid-run code", int'(res_code), 1);
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_clamp_and_size();
        t_nodev();
        t_busy_poll();
        t_too_big();
        t_tmo_retry();
        t_rx_backoff();
        t_div_seq();
        t_hold();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule